// File: doc/BRIEF.md
# DDR Byte-Lane Data Path

This block carries one byte lane of a memory-style bus at double data rate, with a strobe that travels with the data. Toward the core it looks like a single-data-rate port twice the lane width. Each core word holds an even beat in its lower half and an odd beat in its upper half.

In write mode the block takes one core word per accepted cycle. It puts the even beat on the lane while the clock is high and the odd beat while the clock is low. It drives a strobe that comes from an externally supplied 90-degree clock, so each strobe edge falls in the middle of its data bit. In read mode the far end drives the strobe. The strobe arrives at `dqs_in` already shifted by a quarter cycle, because the delay element sits outside this block. Rising strobe edges capture even beats and falling edges capture odd beats. Each completed pair goes into a two-entry holding register. The core clock domain then picks up each pair and presents it as a double-wide word with a one-cycle valid pulse.

The core clock and the strobe are assumed to come from the same source, at the same frequency and with a fixed phase relation. The delay-locked loop, the pad drivers and the PLL are outside the block.

Top module: `ddr_lane_phy`

## Requirements
- R1: The lane width parameter must be 8 or 9. Any other value stops elaboration with an error.
- R2: A word is accepted on a rising `clk` edge when `wr_mode`=1 and `wr_valid`=1. In that same cycle, bits [W-1:0] drive `dq_out` while `clk` is high, and bits [2W-1:W] drive it while `clk` is low.
- R3: In a cycle that carries an accepted word, `dqs_out` follows `clk90`. It rises a quarter cycle after the rising `clk` edge and falls a quarter cycle after the falling edge. In a cycle without a word, `dqs_out` stays 0.
- R4: `dqs_n_out` is always the complement of `dqs_out`.
- R5: `dq_oe` and `dqs_oe` are 1 from the first rising edge at which `wr_mode`=1 is sampled, and 0 from the first edge at which `wr_mode`=0 is sampled. The strobe toggles only while the enables are 1.
- R6: On a rising `dqs_in` edge the block captures `dq_in` as the even beat. On a falling edge it captures the odd beat. The pair is delivered as {odd, even}, with the even beat in bits [W-1:0].
- R7: In read mode (`wr_mode`=0), each completed pair raises `rd_valid` for exactly one core cycle. Pairs are delivered in arrival order, and none is lost or repeated, even at one pair per cycle.
- R8: While reset is asserted: `dq_oe`=0, `dqs_oe`=0, `dqs_out`=0, `dqs_n_out`=1, `rd_valid`=0, and the beat registers hold 0, so `dq_out`=0.
- R9: While `wr_mode`=0, `wr_valid` is ignored: no strobe edge is produced and no word reaches the far end.
- R10: Between `rd_valid` pulses, `rd_data` holds the last delivered word.

Port widths below use W for the lane width parameter `LANE_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; its level also selects the beat on the lane |
| clk90 | input | 1 | Core clock delayed by a quarter cycle, used as the write strobe source |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_mode | input | 1 | 1 = write (block drives the lane), 0 = read |
| wr_valid | input | 1 | Core word present on `wr_data` this cycle |
| wr_data | input | 2W | Core word {odd beat, even beat} |
| dq_out | output | W | Lane data to the pads |
| dq_oe | output | 1 | Output enable for the lane data |
| dqs_out | output | 1 | True side of the strobe |
| dqs_n_out | output | 1 | Complement side of the strobe |
| dqs_oe | output | 1 | Output enable for the strobe pair |
| dq_in | input | W | Lane data from the pads |
| dqs_in | input | 1 | Incoming strobe, already shifted by a quarter cycle |
| rd_valid | output | 1 | One-cycle pulse when a captured pair is delivered |
| rd_data | output | 2W | Delivered word {odd beat, even beat} |

## Verification
The hardest case to reach is the holding register running full: a new pair lands in the strobe domain every cycle while the core side is still retiming the previous write pointer. The bench reaches it by looping one instance in write mode into a second instance in read mode, with wire delays on the data and strobe. It then streams long runs of back-to-back random words, mixed with random gaps, and a scoreboard checks that each word returns once and in order. A stretch in which `wr_valid` is held high in read mode checks that no stray strobe edge leaks into the capture side.

// File: rtl/ddr_lane_pkg.sv
`timescale 1ns/1ps
package ddr_lane_pkg;
   typedef enum logic {
      DIR_READ  = 1'b0,
      DIR_WRITE = 1'b1
   } lane_dir_e;

   localparam int HOLD_SLOTS = 2;

   function automatic bit lane_width_ok(input int w);
      return (w == 8) || (w == 9);
   endfunction
endpackage

// File: rtl/ddr_tx_serializer.sv
`timescale 1ns/1ps
module ddr_tx_serializer #(
   parameter int LANE_W = 8,
   localparam int DW = 2 * LANE_W
) (
   input  logic              clk,
   input  logic              clk90,
   input  logic              rst_n,
   input  logic              write_sel,
   input  logic              wr_valid,
   input  logic [DW-1:0]     wr_data,
   output logic [LANE_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              dqs_out,
   output logic              dqs_oe
);
   logic [LANE_W-1:0] even_q, odd_q;
   logic              burst_q, drive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         even_q  <= '0;
         odd_q   <= '0;
         burst_q <= 1'b0;
         drive_q <= 1'b0;
      end else begin
         drive_q <= write_sel;
         burst_q <= write_sel & wr_valid;
         if (write_sel && wr_valid) begin
            even_q <= wr_data[LANE_W-1:0];
            odd_q  <= wr_data[DW-1:LANE_W];
         end
      end
   end

   // The clock level switches each bit between its two beat registers.
   for (genvar b = 0; b < LANE_W; b++) begin : g_beat_mux
      assign dq_out[b] = clk ? even_q[b] : odd_q[b];
   end

   // burst_q changes only at a rising clk edge, where clk90 is low, so the gate cannot glitch.
   assign dqs_out = burst_q & clk90;
   assign dq_oe   = drive_q;
   assign dqs_oe  = drive_q;

   p_strobe_enabled_r5: assert property (@(negedge clk90) disable iff (!rst_n)
      dqs_out |-> (dq_oe && dqs_oe))
      else $error("strobe toggled with enables low");
endmodule

// File: rtl/ddr_rx_capture.sv
`timescale 1ns/1ps
module ddr_rx_capture #(
   parameter int LANE_W = 8,
   localparam int DW = 2 * LANE_W,
   localparam int SLOTS = ddr_lane_pkg::HOLD_SLOTS
) (
   input  logic                      rst_n,
   input  logic                      dqs_in,
   input  logic [LANE_W-1:0]         dq_in,
   output logic [SLOTS-1:0][DW-1:0]  slots,
   output logic                      wptr
);
   logic [LANE_W-1:0] even_cap;

   // Even beat: rising strobe edge.
   always_ff @(posedge dqs_in or negedge rst_n) begin
      if (!rst_n) even_cap <= '0;
      else        even_cap <= dq_in;
   end

   // Odd beat: falling edge; the pair is stored and the write pointer moves.
   always_ff @(negedge dqs_in or negedge rst_n) begin
      if (!rst_n) begin
         slots <= '0;
         wptr  <= 1'b0;
      end else begin
         slots[wptr] <= {dq_in, even_cap};
         wptr        <= ~wptr;
      end
   end
endmodule

// File: rtl/ddr_rx_handoff.sv
`timescale 1ns/1ps
module ddr_rx_handoff #(
   parameter int LANE_W = 8,
   localparam int DW = 2 * LANE_W,
   localparam int SLOTS = ddr_lane_pkg::HOLD_SLOTS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     read_sel,
   input  logic [SLOTS-1:0][DW-1:0] slots,
   input  logic                     wptr,
   output logic                     rd_valid,
   output logic [DW-1:0]            rd_data
);
   logic ptr_s1, rptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_s1   <= 1'b0;
         rptr     <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         ptr_s1   <= wptr;
         rd_valid <= 1'b0;
         if (ptr_s1 != rptr) begin
            rptr <= ~rptr;
            if (read_sel) begin
               rd_data  <= slots[rptr];
               rd_valid <= 1'b1;
            end
         end
      end
   end

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> $stable(rd_data))
      else $error("rd_data changed without a valid pulse");
endmodule

// File: rtl/ddr_lane_phy.sv
`timescale 1ns/1ps
module ddr_lane_phy #(
   parameter int LANE_W = 8,
   localparam int DW = 2 * LANE_W
) (
   input  logic              clk,
   input  logic              clk90,
   input  logic              rst_n,
   input  logic              wr_mode,
   input  logic              wr_valid,
   input  logic [DW-1:0]     wr_data,
   output logic [LANE_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              dqs_out,
   output logic              dqs_n_out,
   output logic              dqs_oe,
   input  logic [LANE_W-1:0] dq_in,
   input  logic              dqs_in,
   output logic              rd_valid,
   output logic [DW-1:0]     rd_data
);
   import ddr_lane_pkg::*;

   if (!lane_width_ok(LANE_W)) begin : g_bad_width_r1
      $error("LANE_W must be 8 or 9");
   end

   logic write_sel;
   logic ptr_w;
   logic [HOLD_SLOTS-1:0][DW-1:0] hold;

   assign write_sel = (lane_dir_e'(wr_mode) == DIR_WRITE);

   ddr_tx_serializer #(.LANE_W(LANE_W)) tx_i (
      .clk(clk), .clk90(clk90), .rst_n(rst_n), .write_sel(write_sel),
      .wr_valid(wr_valid), .wr_data(wr_data), .dq_out(dq_out),
      .dq_oe(dq_oe), .dqs_out(dqs_out), .dqs_oe(dqs_oe));

   assign dqs_n_out = ~dqs_out;

   ddr_rx_capture #(.LANE_W(LANE_W)) cap_i (
      .rst_n(rst_n), .dqs_in(dqs_in), .dq_in(dq_in),
      .slots(hold), .wptr(ptr_w));

   ddr_rx_handoff #(.LANE_W(LANE_W)) hand_i (
      .clk(clk), .rst_n(rst_n), .read_sel(~write_sel),
      .slots(hold), .wptr(ptr_w), .rd_valid(rd_valid), .rd_data(rd_data));

   p_valid_not_driving_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !dq_oe)
      else $error("read pulse while lane is driven");

   p_reset_quiet_r8: assert property (@(posedge clk)
      !rst_n |=> (!dq_oe && !dqs_oe && !dqs_out))
      else $error("lane active during reset");
endmodule

// File: tb/ddr_lane_phy_tb_top.sv
`timescale 1ns/1ps
module ddr_lane_phy_tb_top;
   localparam int W  = 8;
   localparam int DW = 2 * W;

   logic clk, clk90, rst_n;
   logic dut_mode, dut_valid;
   logic [DW-1:0] dut_wdata;
   logic [W-1:0]  dut_dq;
   logic dut_dq_oe, dut_dqs, dut_dqs_n, dut_dqs_oe, dut_rv;
   logic [DW-1:0] dut_rd;

   wire [W-1:0] lp_dq;
   wire         lp_dqs;
   logic [W-1:0]  pr_dq;
   logic pr_dq_oe, pr_dqs, pr_dqs_n, pr_dqs_oe, pr_rv;
   logic [DW-1:0] pr_rd;

   int total = 0, bad = 0, sent = 0, got = 0;
   bit done = 0;
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] last_word;

   initial begin
      clk = 0; clk90 = 0;
      #2;
      forever begin
         clk = 1; #1 clk90 = 1; #1 clk = 0; #1 clk90 = 0; #1;
      end
   end

   assign #0.5 lp_dq  = dut_dq;
   assign #0.5 lp_dqs = dut_dqs;

   ddr_lane_phy #(.LANE_W(W)) dut_i (
      .clk(clk), .clk90(clk90), .rst_n(rst_n), .wr_mode(dut_mode),
      .wr_valid(dut_valid), .wr_data(dut_wdata), .dq_out(dut_dq),
      .dq_oe(dut_dq_oe), .dqs_out(dut_dqs), .dqs_n_out(dut_dqs_n),
      .dqs_oe(dut_dqs_oe), .dq_in('0), .dqs_in(1'b0),
      .rd_valid(dut_rv), .rd_data(dut_rd));

   ddr_lane_phy #(.LANE_W(W)) peer_i (
      .clk(clk), .clk90(clk90), .rst_n(rst_n), .wr_mode(1'b0),
      .wr_valid(1'b0), .wr_data('0), .dq_out(pr_dq),
      .dq_oe(pr_dq_oe), .dqs_out(pr_dqs), .dqs_n_out(pr_dqs_n),
      .dqs_oe(pr_dqs_oe), .dq_in(lp_dq), .dqs_in(lp_dqs),
      .rd_valid(pr_rv), .rd_data(pr_rd));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: pops expected words as the read side delivers them.
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (dut_rv) chk(0, "R7 pulse on write-mode instance", 32'(dut_rv), 0);
         if (pr_rv) begin
            got++;
            if (exp_q.size() == 0) chk(0, "R7 unexpected word", 32'(pr_rd), 0);
            else begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               chk(pr_rd == e, "R6 R7 word order/content", 32'(pr_rd), 32'(e));
               last_word = e;
            end
         end
      end
   end

   // Directed word with timing checks on the lane (R2 R3 R4).
   task automatic send_checked(input logic [DW-1:0] w);
      @(negedge clk);
      dut_valid = 1; dut_wdata = w; exp_q.push_back(w); sent++;
      @(posedge clk);
      #0.5;
      dut_valid = 0;
      chk(dut_dq == w[W-1:0], "R2 even beat in high phase", 32'(dut_dq), 32'(w[W-1:0]));
      chk(dut_dqs == 0, "R3 strobe low before quarter", 32'(dut_dqs), 0);
      #1;
      chk(dut_dqs == 1, "R3 strobe rises at quarter", 32'(dut_dqs), 1);
      chk(dut_dqs_n == 0, "R4 complement low", 32'(dut_dqs_n), 0);
      #1;
      chk(dut_dq == w[DW-1:W], "R2 odd beat in low phase", 32'(dut_dq), 32'(w[DW-1:W]));
      #1;
      chk(dut_dqs == 0 && dut_dqs_n == 1, "R3 R4 strobe falls at three quarters",
          {dut_dqs, dut_dqs_n}, 32'b01);
   endtask

   task automatic stream(input int n, input int gap_pct);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (($urandom % 100) < gap_pct) dut_valid = 0;
         else begin
            dut_valid = 1;
            dut_wdata = DW'($urandom);
            exp_q.push_back(dut_wdata);
            sent++;
         end
      end
      @(negedge clk);
      dut_valid = 0;
   endtask

   initial begin
      rst_n = 1; dut_mode = 1; dut_valid = 0; dut_wdata = '0;
      #1 rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!dut_dq_oe && !dut_dqs_oe, "R8 enables low in reset", {dut_dq_oe, dut_dqs_oe}, 0);
      chk(dut_dqs == 0 && dut_dqs_n == 1, "R8 strobe idle pair", {dut_dqs, dut_dqs_n}, 32'b01);
      chk(dut_dq == 0, "R8 beat registers clear", 32'(dut_dq), 0);
      chk(pr_rv == 0 && pr_rd == 0, "R8 read side clear", {pr_rv, 16'(pr_rd)}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(dut_dq_oe && dut_dqs_oe, "R5 enables high in write mode", {dut_dq_oe, dut_dqs_oe}, 32'b11);
      chk(!pr_dq_oe && !pr_dqs_oe, "R5 read-mode instance tri-stated", {pr_dq_oe, pr_dqs_oe}, 0);
      @(posedge clk); #1.5;
      chk(dut_dqs == 0, "R3 no strobe without word", 32'(dut_dqs), 0);

      send_checked(16'hA55A);
      send_checked(16'h0FF0);
      repeat (4) @(negedge clk);
      chk(got == 2, "R7 two directed words delivered", 32'(got), 2);
      chk(pr_rd == 16'h0FF0 && !pr_rv, "R10 read data holds", 32'(pr_rd), 32'h0FF0);

      stream(200, 0);
      stream(300, 35);
      repeat (6) @(negedge clk);
      chk(exp_q.size() == 0 && got == sent, "R7 stream fully delivered", 32'(got), 32'(sent));

      // Read mode: wr_valid must be ignored (R9) and enables drop (R5).
      @(negedge clk);
      dut_mode = 0; dut_valid = 1; dut_wdata = 16'hDEAD;
      @(negedge clk);
      chk(!dut_dq_oe && !dut_dqs_oe, "R5 enables low in read mode", {dut_dq_oe, dut_dqs_oe}, 0);
      @(posedge clk); #1.5;
      chk(dut_dqs == 0, "R9 no strobe in read mode", 32'(dut_dqs), 0);
      repeat (4) @(negedge clk);
      dut_valid = 0;
      repeat (4) @(negedge clk);
      chk(got == sent, "R9 nothing delivered from read-mode request", 32'(got), 32'(sent));
      chk(pr_rd == last_word, "R10 data held across idle", 32'(pr_rd), 32'(last_word));

      dut_mode = 1;
      @(negedge clk);
      @(negedge clk);
      chk(dut_dq_oe, "R5 enables return in write mode", 32'(dut_dq_oe), 1);
      stream(100, 10);
      repeat (6) @(negedge clk);
      chk(exp_q.size() == 0 && got == sent, "R7 final stream delivered", 32'(got), 32'(sent));

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R7 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule